// File: doc/BRIEF.md
# Self-Timed Erase Sequencer with Unit Protection

This block sits between a command decoder and a flash storage array and carries out erase requests without further help from the decoder. A request names either one erase unit or the whole device. There are thirty-three erase units: a small first unit of 8 pages, the remaining 248 pages of sector 0, and sectors 1 to 31 at 256 pages each. Together they cover the 8192-page array. Each unit has a protection bit and a lockdown bit. If either bit is set, the unit is never erased.

A request is offered on a valid/ready handshake. The sequencer raises `req_ready` only while it is idle, so a request is taken in the cycle where `req_valid` and `req_ready` are both high. The block never stores a request. A request offered while it is busy is not taken, and the decoder is expected to drop it. For each unit it erases, the block pulses `erase_stb` for one cycle, together with the unit index, its first page and its page count. It then waits a fixed number of cycles, set by a parameter, for that unit to finish. A whole-device request visits every unit in ascending order and passes over the protected ones. While an operation runs, `rdy_busy` is low and `status_busy` is high.

Top module: `erase_seq`

## Requirements
- R1: Unit index 0 is pages 0..7, index 1 is pages 8..255, and index k in 2..32 is sector k-1, which is pages (k-1)*256 .. (k-1)*256+255. Each `erase_stb` pulse carries the index on `erase_unit`, the first page on `erase_page` and the page count on `erase_count`.
- R2: A single-unit request (`req_chip`=0) for an unprotected unit produces exactly one strobe, in the cycle after acceptance. The operation stays busy for 1+ERASE_CYCLES cycles.
- R3: A unit whose bit is set in `prot_mask` or in `lock_mask` (bit i belongs to unit i) is never strobed.
- R4: From the cycle after acceptance until the operation ends, `status_busy` is 1 and `rdy_busy` is 0. Both return to the ready values in the cycle after the last unit's time has elapsed.
- R5: A whole-device erase with nothing protected strobes page ranges that are contiguous, start at page 0 and end at page 8191.
- R6: A whole-device erase visits units 0..32 in ascending order. Each unprotected unit gets one cycle with its strobe, followed by ERASE_CYCLES cycles of waiting. Each protected unit takes one cycle with no strobe. The busy length is therefore 33 + ERASE_CYCLES × (number of unprotected units).
- R7: A single-unit request for a protected unit, or for an index of 33 or above, produces no strobe. It stays busy for 1+SKIP_CYCLES cycles.
- R8: While busy, `req_ready` is 0. A request offered then has no effect on strobes or on the busy length.
- R9: A synchronous reset (`rst`=1) aborts any operation. In the cycle after reset, `rdy_busy`=1, `status_busy`=0 and there is no strobe.
- R10: `req_ready` is 1 when idle. When `req_chip`=1, the value of `req_unit` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Erase request offered |
| req_ready | output | 1 | High when a request can be taken (idle) |
| req_chip | input | 1 | 1: erase whole device, 0: erase one unit |
| req_unit | input | 6 | Unit index for a single-unit request |
| prot_mask | input | 33 | Per-unit protection bits |
| lock_mask | input | 33 | Per-unit lockdown bits |
| rdy_busy | output | 1 | Ready/busy pin: 1 ready, 0 busy |
| status_busy | output | 1 | Busy status bit |
| erase_stb | output | 1 | One-cycle erase command to the array |
| erase_unit | output | 6 | Unit index being erased |
| erase_page | output | 13 | First page of that unit |
| erase_count | output | 9 | Page count of that unit |

## Verification
The assertions read the protection and lockdown masks in the same cycle as a strobe. They therefore assume the masks do not change in the middle of an operation, and the stimulus changes the masks only while the sequencer is idle. The spacing and ordering checks assume ERASE_CYCLES and SKIP_CYCLES are at least 1, and the bench uses small values of both. Requests offered during a busy period are generated on purpose. The bench keeps them from lingering into the idle cycle by clearing `req_valid` before the first ready edge.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_EVAL = 2'd1,
    SQ_WAIT = 2'd2,
    SQ_SKIP = 2'd3
  } seq_state_t;
endpackage

// File: rtl/erase_unit_map.sv
// Maps an erase-unit index to its first page and page count.
module erase_unit_map #(
  parameter int SUB0A_PAGES      = 8,
  parameter int PAGES_PER_SECTOR = 256,
  parameter int UW               = 6,
  parameter int PW               = 13,
  parameter int CW               = 9
) (
  input  logic [UW-1:0] unit,
  output logic [PW-1:0] base,
  output logic [CW-1:0] count
);
  always_comb begin
    if (unit == '0) begin
      base  = '0;
      count = CW'(SUB0A_PAGES);
    end else if (unit == UW'(1)) begin
      base  = PW'(SUB0A_PAGES);
      count = CW'(PAGES_PER_SECTOR - SUB0A_PAGES);
    end else begin
      base  = (PW'(unit) - PW'(1)) * PW'(PAGES_PER_SECTOR);
      count = CW'(PAGES_PER_SECTOR);
    end
  end
endmodule

// File: rtl/erase_guard.sv
// Merges protection and lockdown bits; indices past the last unit count as denied.
module erase_guard #(
  parameter int UNITS = 33,
  parameter int UW    = 6
) (
  input  logic [UW-1:0]    unit,
  input  logic [UNITS-1:0] prot_mask,
  input  logic [UNITS-1:0] lock_mask,
  output logic             blocked
);
  localparam int SLOTS = 1 << UW;
  logic [SLOTS-1:0] deny;

  always_comb begin
    deny              = '1;
    deny[UNITS-1:0]   = prot_mask | lock_mask;
  end

  assign blocked = deny[unit];
endmodule

// File: rtl/erase_timer.sv
// Down counter: load sets the count, expired is high once it reaches zero.
module erase_timer #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - TW'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_seq_pkg::*;
#(
  parameter int N_SECTORS        = 32,
  parameter int SUB0A_PAGES      = 8,
  parameter int PAGES_PER_SECTOR = 256,
  parameter int ERASE_CYCLES     = 1000,
  parameter int SKIP_CYCLES      = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_chip,
  input  logic [5:0]  req_unit,
  input  logic [32:0] prot_mask,
  input  logic [32:0] lock_mask,
  output logic        rdy_busy,
  output logic        status_busy,
  output logic        erase_stb,
  output logic [5:0]  erase_unit,
  output logic [12:0] erase_page,
  output logic [8:0]  erase_count
);
  localparam int UNITS       = N_SECTORS + 1;
  localparam int UW          = $clog2(UNITS);
  localparam int TOTAL_PAGES = N_SECTORS * PAGES_PER_SECTOR;
  localparam int PW          = $clog2(TOTAL_PAGES);
  localparam int CW          = $clog2(PAGES_PER_SECTOR + 1);
  localparam int TMAX        = (ERASE_CYCLES > SKIP_CYCLES) ? ERASE_CYCLES : SKIP_CYCLES;
  localparam int TW          = $clog2(TMAX + 1);

  seq_state_t    state_q;
  logic          chip_q;
  logic [UW-1:0] unit_q;
  logic          blocked;
  logic          expired;
  logic          last_unit;
  logic          take;

  assign take      = req_valid && (state_q == SQ_IDLE);
  assign last_unit = (unit_q == UW'(UNITS - 1));

  erase_guard #(.UNITS(UNITS), .UW(UW)) u_guard (
    .unit      (unit_q),
    .prot_mask (prot_mask),
    .lock_mask (lock_mask),
    .blocked   (blocked)
  );

  erase_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (state_q == SQ_EVAL),
    .load_val (blocked ? TW'(SKIP_CYCLES - 1) : TW'(ERASE_CYCLES - 1)),
    .expired  (expired)
  );

  erase_unit_map #(
    .SUB0A_PAGES      (SUB0A_PAGES),
    .PAGES_PER_SECTOR (PAGES_PER_SECTOR),
    .UW               (UW),
    .PW               (PW),
    .CW               (CW)
  ) u_map (
    .unit  (unit_q),
    .base  (erase_page),
    .count (erase_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      chip_q  <= 1'b0;
      unit_q  <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (take) begin
          state_q <= SQ_EVAL;
          chip_q  <= req_chip;
          unit_q  <= req_chip ? '0 : req_unit;
        end
        SQ_EVAL: begin
          if (!blocked)          state_q <= SQ_WAIT;
          else if (!chip_q)      state_q <= SQ_SKIP;
          else if (last_unit)    state_q <= SQ_IDLE;
          else                   unit_q  <= unit_q + UW'(1);
        end
        SQ_WAIT: if (expired) begin
          if (chip_q && !last_unit) begin
            unit_q  <= unit_q + UW'(1);
            state_q <= SQ_EVAL;
          end else begin
            state_q <= SQ_IDLE;
          end
        end
        SQ_SKIP: if (expired) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign req_ready   = (state_q == SQ_IDLE);
  assign status_busy = (state_q != SQ_IDLE);
  assign rdy_busy    = ~status_busy;
  assign erase_stb   = (state_q == SQ_EVAL) && !blocked;
  assign erase_unit  = unit_q;
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk #(
  parameter int UNITS = 33,
  parameter int TOTAL = 8192
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rdy_busy,
  input logic        status_busy,
  input logic        erase_stb,
  input logic [5:0]  erase_unit,
  input logic [12:0] erase_page,
  input logic [8:0]  erase_count,
  input logic [32:0] prot_mask,
  input logic [32:0] lock_mask
);
  logic       seen_q;
  logic [5:0] last_q;

  always_ff @(posedge clk) begin
    if (rst || !status_busy) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (erase_stb) begin
      seen_q <= 1'b1;
      last_q <= erase_unit;
    end
  end

  AST_STB_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    erase_stb |-> (erase_unit < 6'(UNITS))); // R1
  AST_FIRST_UNIT_PAGE0: assert property (@(posedge clk) disable iff (rst)
    (erase_stb && erase_unit == '0) |-> (erase_page == '0)); // R1
  AST_STB_UNPROTECTED: assert property (@(posedge clk) disable iff (rst)
    erase_stb |-> !(prot_mask[erase_unit] || lock_mask[erase_unit])); // R3
  AST_STB_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    erase_stb |-> (status_busy && !rdy_busy)); // R4
  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> status_busy); // R4
  AST_PAGE_BOUND: assert property (@(posedge clk) disable iff (rst)
    erase_stb |-> ({1'b0, erase_page} + 14'(erase_count) <= 14'(TOTAL))); // R5
  AST_STB_SPACED: assert property (@(posedge clk) disable iff (rst)
    erase_stb |=> !erase_stb); // R6
  AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
    (erase_stb && seen_q) |-> (erase_unit > last_q)); // R6
  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (rst)
    !rdy_busy |-> !req_ready); // R8
endmodule

bind erase_seq erase_seq_chk #(
  .UNITS (N_SECTORS + 1),
  .TOTAL (N_SECTORS * PAGES_PER_SECTOR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rdy_busy    (rdy_busy),
  .status_busy (status_busy),
  .erase_stb   (erase_stb),
  .erase_unit  (erase_unit),
  .erase_page  (erase_page),
  .erase_count (erase_count),
  .prot_mask   (prot_mask),
  .lock_mask   (lock_mask)
);

// File: tb/sim_erase_seq.sv
module sim_erase_seq;
  localparam int T = 5;
  localparam int S = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_chip = 1'b0;
  logic [5:0]  req_unit = '0;
  logic [32:0] prot_mask = '0;
  logic [32:0] lock_mask = '0;
  logic        rdy_busy, status_busy, erase_stb;
  logic [5:0]  erase_unit;
  logic [12:0] erase_page;
  logic [8:0]  erase_count;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  erase_seq #(.ERASE_CYCLES(T), .SKIP_CYCLES(S)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_chip(req_chip), .req_unit(req_unit), .prot_mask(prot_mask),
    .lock_mask(lock_mask), .rdy_busy(rdy_busy), .status_busy(status_busy),
    .erase_stb(erase_stb), .erase_unit(erase_unit), .erase_page(erase_page),
    .erase_count(erase_count)
  );

  function automatic int f_base(int u);
    if (u == 0) return 0;
    if (u == 1) return 8;
    return (u - 1) * 256;
  endfunction

  function automatic int f_cnt(int u);
    if (u == 0) return 8;
    if (u == 1) return 248;
    return 256;
  endfunction

  function automatic bit f_blocked(int u);
    if (u > 32) return 1'b1;
    return prot_mask[u] | lock_mask[u];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      chk(1'b0, "WATCHDOG", "cycle limit", cycles, 150000);
      finish_run();
    end
  end

  // Runs one request; noise offers extra requests while busy.
  task automatic run_op(input bit chip, input int unit, input bit noise);
    int e_pos[40], e_u[40];
    int g_pos[40], g_u[40], g_pg[40], g_ct[40];
    int ne = 0, ng = 0, pos = 1, exp_len, len = 0, k = 1;
    bit refused = 1'b1, flags_ok = 1'b1, maps_ok = 1'b1;
    if (chip) begin
      for (int u = 0; u < 33; u++) begin
        if (f_blocked(u)) pos += 1;
        else begin e_pos[ne] = pos; e_u[ne] = u; ne++; pos += 1 + T; end
      end
      exp_len = pos - 1;
    end else if (f_blocked(unit)) begin
      exp_len = 1 + S;
    end else begin
      e_pos[0] = 1; e_u[0] = unit; ne = 1; exp_len = 1 + T;
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_chip = chip;
    req_unit = chip ? 6'($urandom_range(0, 63)) : 6'(unit);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rdy_busy && k < 5000) begin
      len++;
      if (!status_busy) flags_ok = 1'b0;
      if (req_ready) refused = 1'b0;
      if (erase_stb && ng < 40) begin
        g_pos[ng] = k; g_u[ng] = int'(erase_unit);
        g_pg[ng] = int'(erase_page); g_ct[ng] = int'(erase_count); ng++;
      end
      if (noise) begin
        req_valid = 1'($urandom_range(0, 1));
        req_chip = 1'($urandom_range(0, 1));
        req_unit = 6'($urandom_range(0, 40));
      end
      k++;
      @(negedge clk);
      req_valid = 1'b0;
    end
    chk(flags_ok, "R4", "status_busy during op", int'(flags_ok), 1);
    chk(status_busy == 1'b0, "R4", "status_busy after op", int'(status_busy), 0);
    chk(refused, "R8", "req_ready while busy", int'(refused), 1);
    chk(len == exp_len, chip ? "R6" : (ne == 0 ? "R7" : "R2"), "busy length", len, exp_len);
    chk(ng == ne, chip ? "R3" : "R2", "strobe count", ng, ne);
    for (int i = 0; i < ng && i < ne; i++) begin
      if (g_pos[i] != e_pos[i] || g_u[i] != e_u[i]) begin
        chk(1'b0, "R6", "strobe unit/position", g_u[i] * 1000 + g_pos[i], e_u[i] * 1000 + e_pos[i]);
      end
      if (g_pg[i] != f_base(g_u[i]) || g_ct[i] != f_cnt(g_u[i])) maps_ok = 1'b0;
    end
    chk(maps_ok, "R1", "page/count of strobes", int'(maps_ok), 1);
    if (chip && prot_mask == '0 && lock_mask == '0) begin
      int nxt = 0;
      bit cont = 1'b1;
      for (int i = 0; i < ng; i++) begin
        if (g_pg[i] != nxt) cont = 1'b0;
        nxt = g_pg[i] + g_ct[i];
      end
      chk(cont && nxt == 8192, "R5", "coverage end page", nxt, 8192);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(rdy_busy == 1'b1 && status_busy == 1'b0 && erase_stb == 1'b0, "R9",
        "reset state", int'(rdy_busy), 1);
    rst = 1'b0;
    // R2 R1: directed single units at the boundaries
    run_op(1'b0, 0, 1'b0);
    run_op(1'b0, 1, 1'b0);
    run_op(1'b0, 32, 1'b1);
    // R7: invalid index and protected units
    run_op(1'b0, 40, 1'b0);
    prot_mask = 33'h1_0000_0004;
    run_op(1'b0, 2, 1'b0);
    prot_mask = '0; lock_mask = 33'h0_0000_0002;
    run_op(1'b0, 1, 1'b1);
    // R5: whole device, nothing protected
    lock_mask = '0;
    run_op(1'b1, 0, 1'b1);
    // R3 R6: whole device, everything protected by one mask or the other
    prot_mask = 33'h0_AAAA_AAAA; lock_mask = 33'h1_5555_5555;
    run_op(1'b1, 0, 1'b0);
    // R9: reset in the middle of a whole-device erase
    prot_mask = '0; lock_mask = '0;
    @(negedge clk);
    req_valid = 1'b1; req_chip = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(rdy_busy == 1'b1 && status_busy == 1'b0 && erase_stb == 1'b0, "R9",
        "abort by reset", int'(rdy_busy), 1);
    rst = 1'b0;
    // Random mix
    for (int n = 0; n < 40; n++) begin
      prot_mask = 33'({$urandom(), $urandom()}) & 33'({$urandom(), $urandom()});
      lock_mask = 33'({$urandom(), $urandom()}) & 33'({$urandom(), $urandom()})
                  & 33'({$urandom(), $urandom()});
      run_op(1'($urandom_range(0, 3) == 0), int'($urandom_range(0, 36)),
             1'($urandom_range(0, 1)));
    end
    done = 1'b1;
    finish_run();
  end
endmodule